// File: doc/BRIEF.md
# Execute-Stage Write-Back Timing Wheel

This block models when results leave the execute stage of an in-order, single-issue core and reach the register file. When the issue stage sends an instruction, the block records that instruction's destination registers as a bitmask over a fixed register namespace. It stores the mask in a circular slot array, in the slot a fixed distance ahead of the slot that is due now. In every cycle the block reads the due slot and grants register-file write ports to the pending destinations, lowest register number first. It reports the granted registers to the hazard scoreboard so that the scoreboard can retire them.

If the due slot holds more writes than there are write ports, the block raises its stall. The slot keeps only the writes that were not granted, and the block retires them over the following stalled cycles. An upstream stall is ORed into the same output. The wheel moves to the next slot only in a cycle where the stall output is low. Issue requests made while the stall output is high are dropped, because the slot they would target is not advancing.

Top module: `hw_exec_wheel`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `retire_mask` is all zero. With `upstream_stall` low, `stall_out` is low in that cycle.
- R2: An instruction accepted in cycle t (issue_valid high, stall_out low) has its destinations reported on `retire_mask` in cycle t+2, provided no stall occurs in between. Bit i of a mask stands for register i.
- R3: At most one register (WR_PORTS=1) is reported on `retire_mask` per cycle. When several writes are due, the lowest-numbered pending register is reported first.
- R4: `stall_out` is high in any cycle where the due writes include more registers than the write ports can accept.
- R5: Writes that are granted are reported in the same cycle, even when the block is stalled, and are then removed from the pending set. Every due register is reported exactly once.
- R6: While `stall_out` is high the wheel holds, so writes due in later slots are delayed by the number of stalled cycles.
- R7: `upstream_stall` high forces `stall_out` high, and the wheel holds for that cycle.
- R8: An issue request made while `stall_out` is high is ignored, and its destinations are never reported.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| issue_valid | input | 1 | An instruction is being issued this cycle |
| issue_dst | input | NUM_REGS | Destination-register bitmask of the issued instruction |
| upstream_stall | input | 1 | Stall request from the earlier stages |
| retire_mask | output | NUM_REGS | Registers written to the register file this cycle |
| stall_out | output | 1 | Combined pipeline stall |

## Verification
The bench aims at an instruction with three destinations. It must drain in ascending register order across two stalled cycles. A design that grants out of order or reports a register twice would give the wrong mask sequence. A design that advanced during the stall would lose the remaining writes. An issue attempt made during that stall must never show up on the output, or a ghost retirement appears. Issues that follow a stall, and upstream stalls that land on a due slot, check that later slots move by exactly the number of held cycles. A wheel that kept turning would retire those registers too early.

// File: rtl/hw_exec_wheel_pkg.sv
package hw_exec_wheel_pkg;

    localparam int DEF_NUM_REGS = 16;
    localparam int DEF_SLOTS    = 4;
    localparam int DEF_LATENCY  = 2;
    localparam int DEF_WR_PORTS = 1;

    typedef struct packed {
        logic upstream;
        logic ports;
    } stall_src_t;

    typedef enum logic [1:0] {
        WHEEL_RUN      = 2'd0,
        WHEEL_HOLD_WR  = 2'd1,
        WHEEL_HOLD_UP  = 2'd2
    } wheel_mode_e;

    function automatic wheel_mode_e classify(input stall_src_t s);
        if (s.ports)         return WHEEL_HOLD_WR;
        else if (s.upstream) return WHEEL_HOLD_UP;
        else                 return WHEEL_RUN;
    endfunction

endpackage

// File: rtl/hw_slot_ring.sv
module hw_slot_ring #(
    parameter int NREGS   = 16,
    parameter int SLOTS   = 4,
    parameter int LATENCY = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             advance,
    input  logic             ins_en,
    input  logic [NREGS-1:0] ins_mask,
    input  logic [NREGS-1:0] keep_mask,
    output logic [NREGS-1:0] due_mask
);
    localparam int PTR_W = (SLOTS > 1) ? $clog2(SLOTS) : 1;
    localparam logic [PTR_W-1:0] LAT_P = PTR_W'(LATENCY);

    logic [NREGS-1:0] slot_q [SLOTS];
    logic [PTR_W-1:0] head_q;
    logic [PTR_W-1:0] tgt_ptr;

    assign tgt_ptr  = head_q + LAT_P;
    assign due_mask = slot_q[head_q];

    always_ff @(posedge clk) begin
        if (rst) begin
            head_q <= '0;
            for (int i = 0; i < SLOTS; i++) begin
                slot_q[i] <= '0;
            end
        end else begin
            for (int i = 0; i < SLOTS; i++) begin
                if (PTR_W'(i) == head_q) begin
                    slot_q[i] <= advance ? '0 : keep_mask;
                end else if (ins_en && PTR_W'(i) == tgt_ptr) begin
                    slot_q[i] <= slot_q[i] | ins_mask;
                end
            end
            if (advance) begin
                head_q <= head_q + 1'b1;
            end
        end
    end
endmodule

// File: rtl/hw_port_arb.sv
module hw_port_arb #(
    parameter int NREGS = 16,
    parameter int PORTS = 1
) (
    input  logic [NREGS-1:0] pend,
    output logic [NREGS-1:0] grant,
    output logic [NREGS-1:0] left
);
    logic [NREGS-1:0] rem   [PORTS+1];
    logic [NREGS-1:0] pick  [PORTS];

    assign rem[0] = pend;

    for (genvar p = 0; p < PORTS; p++) begin : g_port
        assign pick[p]  = rem[p] & (~rem[p] + 1'b1);
        assign rem[p+1] = rem[p] & ~pick[p];
    end

    always_comb begin
        grant = '0;
        for (int p = 0; p < PORTS; p++) begin
            grant = grant | pick[p];
        end
    end

    assign left = rem[PORTS];
endmodule

// File: rtl/hw_stall_join.sv
module hw_stall_join
    import hw_exec_wheel_pkg::*;
(
    input  logic        port_short,
    input  logic        upstream_stall,
    input  logic        issue_valid,
    output logic        stall,
    output logic        advance,
    output logic        ins_en,
    output wheel_mode_e mode
);
    stall_src_t src;

    assign src.ports    = port_short;
    assign src.upstream = upstream_stall;
    assign mode         = classify(src);
    assign stall        = (mode != WHEEL_RUN);
    assign advance      = !stall;
    assign ins_en       = issue_valid && !stall;
endmodule

// File: rtl/hw_exec_wheel.sv
module hw_exec_wheel
    import hw_exec_wheel_pkg::*;
#(
    parameter int NUM_REGS = DEF_NUM_REGS,
    parameter int SLOTS    = DEF_SLOTS,
    parameter int LATENCY  = DEF_LATENCY,
    parameter int WR_PORTS = DEF_WR_PORTS
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                issue_valid,
    input  logic [NUM_REGS-1:0] issue_dst,
    input  logic                upstream_stall,
    output logic [NUM_REGS-1:0] retire_mask,
    output logic                stall_out
);
    logic [NUM_REGS-1:0] due;
    logic [NUM_REGS-1:0] granted;
    logic [NUM_REGS-1:0] leftover;
    logic                advance;
    logic                ins_en;
    logic                short_ports;
    wheel_mode_e         mode;

    hw_slot_ring #(
        .NREGS   (NUM_REGS),
        .SLOTS   (SLOTS),
        .LATENCY (LATENCY)
    ) u_ring (
        .clk       (clk),
        .rst       (rst),
        .advance   (advance),
        .ins_en    (ins_en),
        .ins_mask  (issue_dst),
        .keep_mask (leftover),
        .due_mask  (due)
    );

    hw_port_arb #(
        .NREGS (NUM_REGS),
        .PORTS (WR_PORTS)
    ) u_arb (
        .pend  (due),
        .grant (granted),
        .left  (leftover)
    );

    assign short_ports = |leftover;

    hw_stall_join u_join (
        .port_short     (short_ports),
        .upstream_stall (upstream_stall),
        .issue_valid    (issue_valid),
        .stall          (stall_out),
        .advance        (advance),
        .ins_en         (ins_en),
        .mode           (mode)
    );

    assign retire_mask = granted;
endmodule

// File: rtl/hw_exec_wheel_chk.sv
module hw_exec_wheel_chk #(
    parameter int NUM_REGS = 16,
    parameter int WR_PORTS = 1
) (
    input logic                clk,
    input logic                rst,
    input logic                upstream_stall,
    input logic [NUM_REGS-1:0] retire_mask,
    input logic                stall_out
);
    assert_reset_clear_R1: assert property (@(posedge clk)
        rst |=> retire_mask == '0);

    assert_port_limit_R3: assert property (@(posedge clk) disable iff (rst)
        $countones(retire_mask) <= WR_PORTS);

    assert_ascending_R3: assert property (@(posedge clk) disable iff (rst)
        (stall_out && !upstream_stall) |=> retire_mask > $past(retire_mask));

    assert_drain_next_R4: assert property (@(posedge clk) disable iff (rst)
        (stall_out && !upstream_stall) |=> retire_mask != '0);

    assert_no_repeat_R5: assert property (@(posedge clk) disable iff (rst)
        stall_out |=> (retire_mask & $past(retire_mask)) == '0);

    assert_upstream_or_R7: assert property (@(posedge clk) disable iff (rst)
        upstream_stall |-> stall_out);
endmodule

bind hw_exec_wheel hw_exec_wheel_chk #(
    .NUM_REGS (NUM_REGS),
    .WR_PORTS (WR_PORTS)
) u_chk (
    .clk            (clk),
    .rst            (rst),
    .upstream_stall (upstream_stall),
    .retire_mask    (retire_mask),
    .stall_out      (stall_out)
);

// File: tb/tb_hw_exec_wheel.sv
`timescale 1ns/100ps
module tb_hw_exec_wheel;
    localparam int NR = 16;

    typedef struct {
        logic [NR-1:0] retire;
        logic          stall;
        string         tag;
    } exp_t;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          issue_valid = 1'b0;
    logic [NR-1:0] issue_dst = '0;
    logic          upstream_stall = 1'b0;
    logic [NR-1:0] retire_mask;
    logic          stall_out;

    int   n_checks = 0;
    int   n_fail = 0;
    bit   finished = 1'b0;
    exp_t exp_q[$];

    logic [NR-1:0] m_slot [4];
    int            m_head = 0;

    always #2 clk = ~clk;

    hw_exec_wheel dut (
        .clk            (clk),
        .rst            (rst),
        .issue_valid    (issue_valid),
        .issue_dst      (issue_dst),
        .upstream_stall (upstream_stall),
        .retire_mask    (retire_mask),
        .stall_out      (stall_out)
    );

    task automatic check(input string tag, input string what,
                         input logic [NR-1:0] act, input logic [NR-1:0] expv);
        n_checks++;
        if (act !== expv) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, expv);
        end
    endtask

    // monitor: pops expected items and compares against the outputs
    always @(negedge clk) begin
        #1;
        if (exp_q.size() > 0) begin
            exp_t e;
            e = exp_q.pop_front();
            check(e.tag, "retire_mask", retire_mask, e.retire);
            check(e.tag, "stall_out", NR'(stall_out), NR'(e.stall));
        end
    end

    // driver: drives one cycle, pushes the expected result, then updates the model
    task automatic step(input logic v, input logic [NR-1:0] d,
                        input logic up, input string tag);
        logic [NR-1:0] due, grant, left;
        logic          st;
        exp_t          e;
        @(negedge clk);
        issue_valid    = v;
        issue_dst      = d;
        upstream_stall = up;
        #0.5;
        due   = m_slot[m_head];
        grant = due & (~due + 1'b1);
        left  = due & ~grant;
        st    = (left != '0) || up;
        e.retire = grant;
        e.stall  = st;
        e.tag    = tag;
        exp_q.push_back(e);
        @(posedge clk);
        m_slot[m_head] = left;
        if (!st) begin
            if (v) m_slot[(m_head + 2) % 4] = m_slot[(m_head + 2) % 4] | d;
            m_head = (m_head + 1) % 4;
        end
    endtask

    task automatic idle(input int n, input string tag);
        for (int i = 0; i < n; i++) step(1'b0, '0, 1'b0, tag);
    endtask

    initial begin
        for (int i = 0; i < 4; i++) m_slot[i] = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        #1;
        check("R1", "retire_mask in reset", retire_mask, '0);
        rst = 1'b0;
        #0.5;
        check("R1", "stall_out after reset", NR'(stall_out), '0);

        // R2: single destination, two-cycle landing
        step(1'b1, NR'(1) << 3, 1'b0, "R2");
        idle(3, "R2");
        // R2: back-to-back issues, boundary registers 0 and 15
        step(1'b1, NR'(1) << 0, 1'b0, "R2");
        step(1'b1, NR'(1) << 15, 1'b0, "R2");
        idle(3, "R2");

        // R3/R4/R5: three destinations drain in ascending order across stalls
        step(1'b1, (NR'(1) << 1) | (NR'(1) << 5) | (NR'(1) << 9), 1'b0, "R3");
        step(1'b0, '0, 1'b0, "R3");
        step(1'b1, NR'(1) << 7, 1'b0, "R8");   // stalled cycle: issue dropped
        step(1'b1, NR'(1) << 7, 1'b0, "R4");
        step(1'b0, '0, 1'b0, "R5");
        idle(4, "R8");

        // R6: the next slot is delayed by the stall
        step(1'b1, (NR'(1) << 2) | (NR'(1) << 4), 1'b0, "R6");
        step(1'b1, NR'(1) << 6, 1'b0, "R6");
        idle(5, "R6");

        // R7: upstream stall holds the wheel
        step(1'b1, NR'(1) << 8, 1'b0, "R7");
        step(1'b0, '0, 1'b1, "R7");
        step(1'b0, '0, 1'b1, "R7");
        idle(3, "R7");

        // R5/R7: upstream stall on top of a port stall
        step(1'b1, (NR'(1) << 10) | (NR'(1) << 11), 1'b0, "R5");
        step(1'b0, '0, 1'b0, "R5");
        step(1'b0, '0, 1'b1, "R5");
        step(1'b0, '0, 1'b1, "R7");
        idle(3, "R5");

        @(negedge clk);
        #2;
        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end
endmodule